// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block is the master side of a link to a SPI NOR serial flash. A requester hands it one operation: an operation code, a 24-bit address and a byte count. The block then drives chip select, serial clock and serial data to run the whole flash transaction. It sends the instruction byte, then the address and dummy bytes that the operation needs, and then streams data bytes out or in. Write data is pulled from the requester one byte at a time through a take strobe. Read data is pushed back with a valid strobe.

Operations that modify the flash are wrapped in extra frames. A separate write-enable frame goes out first. After the modifying frame, the block keeps issuing status-read frames until the busy flag in bit 0 of the status byte is clear. Only then does it signal completion. The serial clock runs at the system clock divided by an even parameter. The idle clock level follows the chosen clock mode.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, cs_n is 1, busy, done, rd_valid and wr_take are 0, and sclk sits at its idle level (0 when MODE3 is 0).
- R2: Each byte is sent most significant bit first with eight sclk pulses. Each sclk high phase lasts exactly CLK_DIV/2 system cycles, where CLK_DIV is even and at least 6. mosi changes only while sclk is low. miso is sampled at the rising sclk edge. While cs_n is 1, sclk holds the idle level (0 for MODE3=0, 1 for MODE3=1).
- R3: The req_op codes select these instruction bytes: 0→0x06, 1→0x04, 2→0x05, 3→0x01, 4→0x03, 5→0x0B, 6→0x02, 7→0xD8, 8→0xC7, 9→0xB9, 10→0xAB. Each operation is one cs_n-low frame that starts with its instruction byte.
- R4: Codes 4, 5, 6 and 7 send three address bytes after the instruction, bits 23:16 first. Code 5 then sends one 0x00 dummy byte and code 10 sends three. Codes 2, 3, 4, 5, 6 and 10 carry req_len data bytes. All other codes carry none.
- R5: Before codes 3, 6, 7 and 8, a one-byte 0x06 frame is sent as a separate cs_n-low frame.
- R6: After codes 3, 6, 7 and 8, two-byte frames (0x05 followed by one read byte) repeat for as long as bit 0 of the read byte is 1. The operation completes after the first frame that returns 0 in that bit.
- R7: Between any two consecutive frames, cs_n stays high for at least 2*CLK_DIV system cycles.
- R8: wr_take pulses for one cycle once per written data byte, inside the frame, and wr_data is taken in that cycle.
- R9: rd_valid pulses once per received data byte of codes 2, 4, 5 and 10, with the byte on rd_data. It never pulses for instruction, address, dummy or status-poll bytes.
- R10: A request is accepted when req_valid is 1 and busy is 0. busy is 1 from the next cycle until completion, and done then pulses for one cycle with busy at 0. req_valid has no effect while busy is 1.
- R11: A request with req_op 11 to 15 is ignored: no frame is sent and busy stays 0.
- R12: A page program (code 6) of 256 data bytes goes out in one frame of 260 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Operation code |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Number of data bytes |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | wr_data consumed this cycle |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock to flash |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | 1 | Active-low flash select |

## Verification
The assertions check the following on every cycle:
- the minimum chip-select gap between frames;
- the idle clock level while deselected;
- the bound on the high-phase length;
- a stable data line while the clock is high;
- that take and valid strobes occur only inside an operation;
- that the done pulse is handshaked correctly.

Some behaviour can only be shown by the bench's scenarios against a behavioural flash model. This covers:
- frame contents and lengths per operation;
- the write-enable prefix;
- the number of status polls before completion;
- bit order through a write and read-back round trip;
- the rejection of unused operation codes and of requests made while busy.

// File: rtl/spi_flash_seq.sv
module spi_flash_seq #(
  parameter int CLK_DIV = 6,
  parameter bit MODE3   = 1'b0,
  parameter int LEN_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int HALF = CLK_DIV / 2;
  localparam int GAP  = 2 * CLK_DIV;
  localparam int CW   = $clog2(GAP + 1);
  localparam int IW   = LEN_W + 2;
  localparam int HW   = $clog2(HALF + 2);

  localparam logic [3:0] OP_WREN = 4'd0, OP_WRDI = 4'd1, OP_RDSR = 4'd2, OP_WRSR = 4'd3,
                         OP_READ = 4'd4, OP_FRD  = 4'd5, OP_PP   = 4'd6, OP_SE   = 4'd7,
                         OP_BE   = 4'd8, OP_DP   = 4'd9, OP_RES  = 4'd10;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOAD, S_SHIFT, S_GAP} st_t;
  typedef enum logic [1:0] {F_WREN, F_MAIN, F_POLL} fr_t;

  st_t             state;
  fr_t             fk;
  logic [IW-1:0]   idx, dstart, last;
  logic [CW-1:0]   cnt;
  logic            h, wip, has_wr, has_rd;
  logic [2:0]      bitn;
  logic [7:0]      sh, rx, opc, tx;
  logic [1:0]      na, nd;
  logic [3:0]      op_q;
  logic [23:0]     addr_q;
  logic [LEN_W-1:0] len_q;

  function automatic logic wants_wren(input logic [3:0] op);
    return op == OP_WRSR || op == OP_PP || op == OP_SE || op == OP_BE;
  endfunction

  always_comb begin
    opc = 8'h00; na = 2'd0; nd = 2'd0; has_wr = 1'b0; has_rd = 1'b0;
    case (op_q)
      OP_WREN: opc = 8'h06;
      OP_WRDI: opc = 8'h04;
      OP_RDSR: begin opc = 8'h05; has_rd = 1'b1; end
      OP_WRSR: begin opc = 8'h01; has_wr = 1'b1; end
      OP_READ: begin opc = 8'h03; na = 2'd3; has_rd = 1'b1; end
      OP_FRD:  begin opc = 8'h0B; na = 2'd3; nd = 2'd1; has_rd = 1'b1; end
      OP_PP:   begin opc = 8'h02; na = 2'd3; has_wr = 1'b1; end
      OP_SE:   begin opc = 8'hD8; na = 2'd3; end
      OP_BE:   opc = 8'hC7;
      OP_DP:   opc = 8'hB9;
      OP_RES:  begin opc = 8'hAB; nd = 2'd3; has_rd = 1'b1; end
      default: opc = 8'h00;
    endcase
  end

  assign dstart = IW'(1) + IW'(na) + IW'(nd);
  assign last = (fk == F_WREN) ? '0 :
                (fk == F_POLL) ? IW'(1) :
                dstart + ((has_wr || has_rd) ? IW'(len_q) : '0) - IW'(1);

  always_comb begin
    tx = 8'h00;
    case (fk)
      F_WREN: tx = 8'h06;
      F_POLL: tx = (idx == '0) ? 8'h05 : 8'h00;
      default: begin
        if (idx == '0) tx = opc;
        else if (idx <= IW'(na))
          case (idx[1:0])
            2'd1:    tx = addr_q[23:16];
            2'd2:    tx = addr_q[15:8];
            default: tx = addr_q[7:0];
          endcase
        else if (has_wr && idx >= dstart) tx = wr_data;
      end
    endcase
  end

  assign wr_take = state == S_LOAD && fk == F_MAIN && has_wr && idx >= dstart;
  assign busy    = state != S_IDLE;
  assign cs_n    = state == S_IDLE || state == S_GAP;
  assign mosi    = sh[7];
  assign sclk    = (state == S_SHIFT) ? h : (state == S_LOAD) ? 1'b0 : MODE3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; fk <= F_MAIN; idx <= '0; cnt <= '0; h <= 1'b0; bitn <= 3'd0;
      sh <= 8'h00; rx <= 8'h00; wip <= 1'b0; op_q <= 4'd0; addr_q <= '0; len_q <= '0;
      rd_data <= 8'h00; rd_valid <= 1'b0; done <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_IDLE:
          if (req_valid && req_op <= OP_RES) begin
            op_q <= req_op; addr_q <= req_addr; len_q <= req_len;
            fk <= wants_wren(req_op) ? F_WREN : F_MAIN;
            idx <= '0; cnt <= '0; state <= S_SETUP;
          end
        S_SETUP:
          if (cnt == CW'(HALF - 1)) begin cnt <= '0; state <= S_LOAD; end
          else cnt <= cnt + 1'b1;
        S_LOAD: begin
          sh <= tx; cnt <= '0; h <= 1'b0; bitn <= 3'd0; state <= S_SHIFT;
        end
        S_SHIFT:
          if (cnt != CW'(HALF - 1)) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            if (!h) begin
              h  <= 1'b1;
              rx <= {rx[6:0], miso};
            end else begin
              h    <= 1'b0;
              sh   <= {sh[6:0], 1'b0};
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) begin
                if (fk == F_MAIN && has_rd && idx >= dstart) begin
                  rd_valid <= 1'b1; rd_data <= rx;
                end
                if (fk == F_POLL) wip <= rx[0];
                if (idx == last) state <= S_GAP;
                else begin idx <= idx + 1'b1; state <= S_LOAD; end
              end
            end
          end
        S_GAP:
          if (cnt != CW'(GAP - 1)) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0; idx <= '0;
            case (fk)
              F_WREN: begin fk <= F_MAIN; state <= S_SETUP; end
              F_MAIN:
                if (wants_wren(op_q)) begin fk <= F_POLL; state <= S_SETUP; end
                else begin state <= S_IDLE; done <= 1'b1; end
              default:
                if (wip) state <= S_SETUP;
                else begin state <= S_IDLE; done <= 1'b1; end
            endcase
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] cs_hi_cnt;
  logic [HW-1:0] hi_cnt;
  logic          seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hi_cnt <= '0; hi_cnt <= '0; seen <= 1'b0;
    end else begin
      if (!cs_n) seen <= 1'b1;
      if (!cs_n) cs_hi_cnt <= '0;
      else if (cs_hi_cnt != CW'(GAP)) cs_hi_cnt <= cs_hi_cnt + 1'b1;
      if (!(sclk && !cs_n)) hi_cnt <= '0;
      else if (hi_cnt != HW'(HALF + 1)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen) |-> cs_hi_cnt >= CW'(GAP)); // R7
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk == MODE3); // R2
  AST_SCLK_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= HW'(HALF)); // R2
  AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk) && !$past(cs_n)) |-> $stable(mosi)); // R2
  AST_TAKE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (!cs_n && !sclk)); // R8
  AST_RD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n)); // R10
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op <= OP_RES) |=> busy); // R10
  AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op > OP_RES) |=> !busy); // R11
endmodule

// File: tb/spi_flash_seq_tb_top.sv
`timescale 1ns/1ps
module spi_flash_seq_tb_top;
  localparam int CLK_DIV = 6;
  localparam int HALF_NS = (CLK_DIV / 2) * 8;
  localparam int GAP_NS  = 2 * CLK_DIV * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_op = 4'd0;
  logic [23:0] req_addr = 24'd0;
  logic [8:0] req_len = 9'd0;
  logic [7:0] wr_data, rd_data;
  logic wr_take, rd_valid, busy, done, sclk, mosi, cs_n;
  logic miso_r = 1'b1;

  always #4 clk = ~clk;

  spi_flash_seq #(.CLK_DIV(CLK_DIV), .MODE3(1'b0), .LEN_W(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .sclk(sclk), .mosi(mosi),
    .miso(miso_r), .cs_n(cs_n));

  int wr_ptr = 0, rd_n = 0, done_n = 0;
  logic [7:0] rdbuf [0:511];
  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction
  assign wr_data = pat(wr_ptr);

  always @(posedge clk) begin
    if (wr_take) wr_ptr <= wr_ptr + 1;
    if (rd_valid) begin rdbuf[rd_n[8:0]] <= rd_data; rd_n <= rd_n + 1; end
    if (done) done_n <= done_n + 1;
  end

  logic [7:0] fbuf [0:299];
  logic [7:0] mem [0:255];
  logic [7:0] frm_op [0:63];
  int frm_len [0:63];
  longint frm_gap [0:63];
  int nfrm = 0, rcnt = 0, bad_hi = 0, busy_cnt = 0, nowel = 0;
  bit wel = 1'b0;
  logic [23:0] pp_hdr = 24'd0;
  logic [7:0] shreg = 8'h00;
  logic pcs = 1'b1, psclk = 1'b0;
  longint t_rise = 0, t_csh = 0;

  function automatic logic [7:0] resp(input int bi);
    if (bi == 0) return 8'hFF;
    case (fbuf[0])
      8'h05: return {6'b0, wel, busy_cnt > 0};
      8'h03: return (bi >= 4) ? mem[8'(fbuf[3] + 8'(bi - 4))] : 8'hFF;
      8'h0B: return (bi >= 5) ? mem[8'(fbuf[3] + 8'(bi - 5))] : 8'hFF;
      8'hAB: return (bi >= 4) ? 8'h10 : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  always @(sclk or cs_n) begin
    if (cs_n !== pcs) begin
      if (cs_n == 1'b0) begin
        rcnt = 0; miso_r = 1'b1;
        if (nfrm < 64) frm_gap[nfrm] = $time - t_csh;
      end else begin
        t_csh = $time;
        if (nfrm < 64) begin frm_op[nfrm] = fbuf[0]; frm_len[nfrm] = rcnt / 8; end
        nfrm = nfrm + 1;
        case (fbuf[0])
          8'h06: wel = 1'b1;
          8'h04: wel = 1'b0;
          8'h05: if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
          8'h02, 8'hD8, 8'hC7, 8'h01:
            if (wel) begin
              if (fbuf[0] == 8'h02) begin
                pp_hdr = {fbuf[1], fbuf[2], fbuf[3]};
                for (int k = 4; k < rcnt / 8; k++) mem[8'(fbuf[3] + 8'(k - 4))] = fbuf[k];
              end
              if (fbuf[0] == 8'hC7) for (int k = 0; k < 256; k++) mem[k] = 8'hFF;
              wel = 1'b0; busy_cnt = 3;
            end else nowel = nowel + 1;
          default: ;
        endcase
      end
    end else if (!cs_n && sclk !== psclk) begin
      if (sclk) begin
        t_rise = $time;
        shreg = {shreg[6:0], mosi};
        rcnt = rcnt + 1;
        if (rcnt % 8 == 0 && rcnt / 8 <= 300) fbuf[rcnt / 8 - 1] = shreg;
      end else begin
        if ($time - t_rise != HALF_NS) bad_hi = bad_hi + 1;
        miso_r = resp(rcnt / 8)[7 - rcnt % 8];
      end
    end
    pcs = cs_n; psclk = sclk;
  end

  int nchk = 0, nerr = 0, f0 = 0, w0 = 0, r0 = 0, pp_w0 = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_frame(input int i, input logic [7:0] op, input int len, input string tag);
    chk(frm_op[f0 + i] == op, {tag, " frame opcode"}, frm_op[f0 + i], op);
    chk(frm_len[f0 + i] == len, {tag, " frame length"}, frm_len[f0 + i], len);
    if (i > 0) chk(frm_gap[f0 + i] >= GAP_NS, "R7 cs_n gap", frm_gap[f0 + i], GAP_NS);
  endtask

  task automatic do_op(input logic [3:0] op, input logic [23:0] a, input int len, input bit poke);
    int d0, cyc;
    f0 = nfrm; w0 = wr_ptr; r0 = rd_n; d0 = done_n;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_len = 9'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    cyc = 0;
    while (done_n == d0 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 100) begin req_valid = 1'b1; req_op = 4'd9; end
      if (poke && cyc == 101) req_valid = 1'b0;
    end
    @(negedge clk);
    chk(done_n - d0 == 1 && done == 1'b0, "R10 single done pulse", done_n - d0, 1);
    chk(busy == 1'b0, "R10 idle after done", busy, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
    chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
    chk(rd_valid == 1'b0 && wr_take == 1'b0, "R1 strobes", {rd_valid, wr_take}, 0);
  endtask

  task automatic t_pp4;
    do_op(4'd6, 24'h012345, 4, 1'b1);
    pp_w0 = w0;
    chk(nfrm - f0 == 6, "R6 R10 frame count for program", nfrm - f0, 6);
    chk_frame(0, 8'h06, 1, "R5");
    chk_frame(1, 8'h02, 8, "R4");
    for (int i = 2; i < 6; i++) chk_frame(i, 8'h05, 2, "R6");
    chk(pp_hdr == 24'h012345, "R4 address order", pp_hdr, 24'h012345);
    chk(wr_ptr - w0 == 4, "R8 take count", wr_ptr - w0, 4);
    chk(rd_n - r0 == 0, "R9 no read strobe", rd_n - r0, 0);
    for (int k = 0; k < 4; k++)
      chk(mem[8'h45 + k] == pat(w0 + k), "R2 written byte", mem[8'h45 + k], pat(w0 + k));
    chk(nowel == 0, "R5 write enable ahead", nowel, 0);
  endtask

  task automatic t_read;
    do_op(4'd4, 24'h012345, 4, 1'b0);
    chk(nfrm - f0 == 1, "R3 read frame count", nfrm - f0, 1);
    chk_frame(0, 8'h03, 8, "R4");
    chk(rd_n - r0 == 4, "R9 read count", rd_n - r0, 4);
    for (int k = 0; k < 4; k++)
      chk(rdbuf[r0 + k] == pat(pp_w0 + k), "R2 R9 read byte", rdbuf[r0 + k], pat(pp_w0 + k));
  endtask

  task automatic t_fast;
    do_op(4'd5, 24'h012346, 3, 1'b0);
    chk_frame(0, 8'h0B, 8, "R4");
    chk(rd_n - r0 == 3, "R9 fast read count", rd_n - r0, 3);
    for (int k = 0; k < 3; k++)
      chk(rdbuf[r0 + k] == pat(pp_w0 + 1 + k), "R4 fast read byte", rdbuf[r0 + k], pat(pp_w0 + 1 + k));
  endtask

  task automatic t_res;
    do_op(4'd10, 24'h0, 1, 1'b0);
    chk_frame(0, 8'hAB, 5, "R4");
    chk(rd_n - r0 == 1 && rdbuf[r0] == 8'h10, "R9 signature", rdbuf[r0], 8'h10);
  endtask

  task automatic t_latch;
    do_op(4'd0, 24'h0, 0, 1'b0);
    chk(nfrm - f0 == 1, "R3 enable frame count", nfrm - f0, 1);
    chk_frame(0, 8'h06, 1, "R3");
    do_op(4'd2, 24'h0, 1, 1'b0);
    chk_frame(0, 8'h05, 2, "R3");
    chk(rdbuf[r0] == 8'h02, "R9 status after enable", rdbuf[r0], 8'h02);
    do_op(4'd1, 24'h0, 0, 1'b0);
    chk_frame(0, 8'h04, 1, "R3");
    do_op(4'd2, 24'h0, 1, 1'b0);
    chk(rdbuf[r0] == 8'h00, "R9 status after disable", rdbuf[r0], 8'h00);
  endtask

  task automatic t_erase;
    do_op(4'd7, 24'h010000, 0, 1'b0);
    chk(nfrm - f0 == 6, "R6 sector erase frames", nfrm - f0, 6);
    chk_frame(0, 8'h06, 1, "R5");
    chk_frame(1, 8'hD8, 4, "R4");
    chk_frame(5, 8'h05, 2, "R6");
    do_op(4'd8, 24'h0, 0, 1'b0);
    chk(nfrm - f0 == 6, "R6 bulk erase frames", nfrm - f0, 6);
    chk_frame(1, 8'hC7, 1, "R3");
    do_op(4'd3, 24'h0, 1, 1'b0);
    chk(nfrm - f0 == 6, "R6 status write frames", nfrm - f0, 6);
    chk_frame(0, 8'h06, 1, "R5");
    chk_frame(1, 8'h01, 2, "R4");
    chk(wr_ptr - w0 == 1, "R8 status write take", wr_ptr - w0, 1);
    do_op(4'd9, 24'h0, 0, 1'b0);
    chk(nfrm - f0 == 1, "R3 power down frames", nfrm - f0, 1);
    chk_frame(0, 8'hB9, 1, "R3");
  endtask

  task automatic t_bad;
    f0 = nfrm;
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'd12;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0, "R11 busy stays low", busy, 0);
    repeat (60) @(negedge clk);
    chk(nfrm - f0 == 0 && cs_n == 1'b1, "R11 no frame", nfrm - f0, 0);
  endtask

  task automatic t_pp256;
    do_op(4'd6, 24'h000000, 256, 1'b0);
    chk_frame(1, 8'h02, 260, "R12");
    chk(wr_ptr - w0 == 256, "R12 take count", wr_ptr - w0, 256);
    chk(mem[255] == pat(w0 + 255), "R12 last byte", mem[255], pat(w0 + 255));
    chk(mem[0] == pat(w0), "R12 first byte", mem[0], pat(w0));
    chk(bad_hi == 0, "R2 sclk high width", bad_hi, 0);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_pp4();
        t_read();
        t_fast();
        t_res();
        t_latch();
        t_erase();
        t_bad();
        t_pp256();
      end
      begin
        repeat (190000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) chk(1'b0, "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule